// File: doc/BRIEF.md
# Multicast Destination Hash Filter

This block decides whether a received frame should be kept, judging only by its 48-bit destination address. For group (multicast) addresses, it takes a slice of the upper address bits as a hash. The hash selects one bit in a table of 32-bit words, and a set bit means the frame is accepted. Software fills the table through a plain word-wide write port. Several addresses can land on the same bit, so software only sets bits, or rewrites whole words. The hardware never clears a bit on its own, except at reset.

Two configuration inputs control the hash. A mode input picks the full-width hash (12 bits, all 128 words in use) or the short hash (10 bits, only words 0 to 31 in use). A 2-bit offset code slides the slice window down the address. Two override inputs act ahead of the table. One accepts every group frame. The other sets the result for every individual (non-group) frame, because exact unicast matching is done elsewhere. A request carries one destination address, and the answer comes back one cycle later.

Top module: `mcast_hash_filter`

## Requirements
- R1: A synchronous active-high reset clears every table word, `resp_valid` and `resp_accept`. A group address looked up right after reset, with the overrides off, is rejected.
- R2: `resp_valid` is high in exactly the cycle after `req_valid` was high. `resp_accept` is 0 whenever `resp_valid` is 0.
- R3: In full mode, the 12-bit hash is the address slice whose lowest bit sits at position 36, 35, 34 or 32 for offset codes 0, 1, 2 and 3. Address byte k occupies bits 8k+7..8k.
- R4: In short mode (`cfg_short_hash`=1), the 12-bit slice is shifted right by 2, giving a 10-bit hash. The word index is then limited to the range 0..31.
- R5: The word index is the hash divided by 32 and the bit position is the hash modulo 32. A group frame is accepted when that table bit is 1.
- R6: A write stores `wr_data` whole into word `wr_idx`, so bits written as 0 are cleared. No bit of the table changes except through such a write or reset.
- R7: A write is seen by lookups from the next cycle. A lookup requested in the same cycle as the write sees the old word contents.
- R8: With `mc_promisc`=1, every group address is accepted, whatever the table holds.
- R9: The group bit is address bit 0. For an address with bit 0 = 0, `resp_accept` equals `uc_promisc` and the table has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table word write strobe |
| wr_idx | input | 7 | Index of the word to write |
| wr_data | input | 32 | Word value to store |
| cfg_short_hash | input | 1 | 1 selects the 10-bit hash (32 words), 0 the 12-bit hash |
| cfg_offset | input | 2 | Selects which address bits form the hash slice |
| uc_promisc | input | 1 | Result returned for non-group addresses |
| mc_promisc | input | 1 | Accept all group addresses |
| req_valid | input | 1 | Lookup request |
| req_dst | input | 48 | Destination address to classify |
| resp_valid | output | 1 | Result valid, one cycle after the request |
| resp_accept | output | 1 | Frame passes the filter |

## Verification
Single-bit table words are probed with addresses whose slice lands on that bit and on its neighbours. This tells a correct divide/modulo split apart from an off-by-one in the word or bit index. Every offset code and both hash widths are run against the same address, so a wrong slice base or a missing shift selects a different bit and is caught. Extra cases cover a write that coincides with a lookup, a whole-word overwrite, unicast addresses against a full table, and a long pseudo-random sweep over all modes and overrides, checked against a bench-side model of the table.

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int HASH_W = 12,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 48,
  parameter int SHORT_DROP = 2
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  wr_en,
  input  logic [HASH_W-$clog2(WORD_W)-1:0]      wr_idx,
  input  logic [WORD_W-1:0]                     wr_data,
  input  logic                                  cfg_short_hash,
  input  logic [1:0]                            cfg_offset,
  input  logic                                  uc_promisc,
  input  logic                                  mc_promisc,
  input  logic                                  req_valid,
  input  logic [ADDR_W-1:0]                     req_dst,
  output logic                                  resp_valid,
  output logic                                  resp_accept
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int IDX_W = HASH_W - BIT_W;
  localparam int WORDS = 1 << IDX_W;
  localparam int LOW0  = ADDR_W - HASH_W;
  localparam int LOW1  = LOW0 - 1;
  localparam int LOW2  = LOW0 - 2;
  localparam int LOW3  = LOW0 - 4;
  localparam logic [IDX_W-1:0] SHORT_MASK = {{SHORT_DROP{1'b0}}, {(IDX_W-SHORT_DROP){1'b1}}};

  logic [WORD_W-1:0] tbl [WORDS];
  logic [HASH_W-1:0] slice, hash;
  logic [IDX_W-1:0]  widx;
  logic [BIT_W-1:0]  bsel;
  logic              group, hit, verdict;

  always_comb begin
    case (cfg_offset)
      2'd0:    slice = req_dst[LOW0 +: HASH_W];
      2'd1:    slice = req_dst[LOW1 +: HASH_W];
      2'd2:    slice = req_dst[LOW2 +: HASH_W];
      default: slice = req_dst[LOW3 +: HASH_W];
    endcase
  end

  assign hash    = cfg_short_hash ? (slice >> SHORT_DROP) : slice;
  assign widx    = hash[HASH_W-1:BIT_W] & (cfg_short_hash ? SHORT_MASK : {IDX_W{1'b1}});
  assign bsel    = hash[BIT_W-1:0];
  assign hit     = tbl[widx][bsel];
  assign group   = req_dst[0];
  assign verdict = group ? (mc_promisc | hit) : uc_promisc;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) tbl[i] <= '0;
      resp_valid  <= 1'b0;
      resp_accept <= 1'b0;
    end else begin
      if (wr_en) tbl[wr_idx] <= wr_data;
      resp_valid  <= req_valid;
      resp_accept <= req_valid & verdict;
    end
  end
endmodule

// File: rtl/mcast_hash_filter_chk.sv
module mcast_hash_filter_chk #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_dst,
  input logic              uc_promisc,
  input logic              mc_promisc,
  input logic              resp_valid,
  input logic              resp_accept
);
  AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst) req_valid |=> resp_valid); // R2
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (rst) !req_valid |=> !resp_valid); // R2
  AST_IDLE_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst) !resp_valid |-> !resp_accept); // R2
  AST_MC_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_dst[0] && mc_promisc) |=> resp_accept); // R8
  AST_UNICAST_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_dst[0]) |=> (resp_accept == $past(uc_promisc))); // R9
endmodule

bind mcast_hash_filter mcast_hash_filter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_dst(req_dst),
  .uc_promisc(uc_promisc), .mc_promisc(mc_promisc),
  .resp_valid(resp_valid), .resp_accept(resp_accept)
);

// File: tb/sim_mcast_hash_filter.sv
module sim_mcast_hash_filter;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [6:0]  wr_idx;
  logic [31:0] wr_data;
  logic        cfg_short_hash;
  logic [1:0]  cfg_offset;
  logic        uc_promisc, mc_promisc;
  logic        req_valid;
  logic [47:0] req_dst;
  logic        resp_valid, resp_accept;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;
  logic [31:0] mirror [128];
  logic [63:0] seed = 64'h1234_5678_9abc_def1;

  always #5 clk = ~clk;

  mcast_hash_filter u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cfg_short_hash(cfg_short_hash), .cfg_offset(cfg_offset),
    .uc_promisc(uc_promisc), .mc_promisc(mc_promisc),
    .req_valid(req_valid), .req_dst(req_dst),
    .resp_valid(resp_valid), .resp_accept(resp_accept)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ref_hash(input logic [47:0] d, input logic sh, input logic [1:0] off);
    int low;
    int h;
    low = (off == 0) ? 36 : (off == 1) ? 35 : (off == 2) ? 34 : 32;
    h = int'((d >> low) & 48'hfff);
    if (sh) h = h >> 2;
    return h;
  endfunction

  function automatic logic ref_accept(input logic [47:0] d);
    int h;
    int w;
    if (!d[0]) return uc_promisc;
    if (mc_promisc) return 1'b1;
    h = ref_hash(d, cfg_short_hash, cfg_offset);
    w = (h / 32) & (cfg_short_hash ? 31 : 127);
    return mirror[w][h % 32];
  endfunction

  function automatic logic [47:0] mk(input int hash12, input logic grp);
    logic [47:0] d;
    d = 48'h0000_0000_0000;
    d[47:36] = hash12[11:0];
    d[0] = grp;
    return d;
  endfunction

  task automatic write_word(input int idx, input logic [31:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx[6:0]; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
    mirror[idx] = val;
  endtask

  task automatic lookup(input string tag, input logic [47:0] d);
    logic exp;
    @(negedge clk);
    exp = ref_accept(d);
    req_valid = 1'b1; req_dst = d;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, {31'd0, resp_valid}, 32'd1);
    check(tag, {31'd0, resp_accept}, {31'd0, exp});
  endtask

  task automatic t_reset;
    rst = 1'b1; wr_en = 0; wr_idx = 0; wr_data = 0; cfg_short_hash = 0; cfg_offset = 0;
    uc_promisc = 0; mc_promisc = 0; req_valid = 0; req_dst = 0;
    for (int i = 0; i < 128; i++) mirror[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 resp_valid after reset", {31'd0, resp_valid}, 32'd0);
    check("R1 resp_accept after reset", {31'd0, resp_accept}, 32'd0);
    rst = 1'b0;
    lookup("R1 empty table rejects", 48'hffff_ffff_ffff);
    lookup("R1 empty table hash abc", mk(12'habc, 1'b1));
  endtask

  task automatic t_timing;
    @(negedge clk);
    @(negedge clk);
    check("R2 no response when idle", {31'd0, resp_valid}, 32'd0);
    check("R2 no accept when idle", {31'd0, resp_accept}, 32'd0);
  endtask

  task automatic t_index;
    write_word(85, 32'h1000_0000);
    lookup("R5 hash abc word 85 bit 28", mk(12'habc, 1'b1));
    check("R5 bit set accepted", {31'd0, resp_accept}, 32'd1);
    lookup("R5 neighbour bit 27", mk(12'habb, 1'b1));
    lookup("R5 neighbour bit 29", mk(12'habd, 1'b1));
    lookup("R5 same bit other word", mk(12'h9bc, 1'b1));
  endtask

  task automatic t_offsets;
    logic [47:0] d;
    d = 48'h5a3c_9e71_c4_01;
    for (int off = 0; off < 4; off++) begin
      cfg_offset = off[1:0];
      for (int i = 0; i < 128; i++) write_word(i, 32'h0);
      write_word(ref_hash(d, 1'b0, off[1:0]) / 32, 32'h1 << (ref_hash(d, 1'b0, off[1:0]) % 32));
      lookup($sformatf("R3 offset %0d target", off), d);
      check($sformatf("R3 offset %0d accepted", off), {31'd0, resp_accept}, 32'd1);
    end
    cfg_offset = 2'd0;
    lookup("R3 offset 0 rejects offset-3 bit", d);
  endtask

  task automatic t_short;
    logic [47:0] d;
    d = mk(12'habc, 1'b1);
    cfg_short_hash = 1'b1;
    for (int i = 0; i < 128; i++) write_word(i, 32'h0);
    write_word(85, 32'hffff_ffff);
    lookup("R4 high word unused in short mode", d);
    write_word(21, 32'h0000_8000);
    lookup("R4 hash 2af word 21 bit 15", d);
    check("R4 short accept", {31'd0, resp_accept}, 32'd1);
    lookup("R4 dropped low bits ignored", mk(12'habf, 1'b1));
    lookup("R4 next hash differs", mk(12'hac0, 1'b1));
    cfg_short_hash = 1'b0;
    lookup("R4 full mode other word", d);
  endtask

  task automatic t_same_cycle;
    logic [47:0] d;
    logic exp;
    d = mk(12'h123, 1'b1);
    write_word(9, 32'h0);
    @(negedge clk);
    exp = ref_accept(d);
    wr_en = 1'b1; wr_idx = 7'd9; wr_data = 32'h0000_0008;
    req_valid = 1'b1; req_dst = d;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    mirror[9] = 32'h0000_0008;
    check("R7 same-cycle lookup sees old", {31'd0, resp_accept}, {31'd0, exp});
    lookup("R7 next lookup sees new", d);
    check("R7 new bit accepted", {31'd0, resp_accept}, 32'd1);
    write_word(9, 32'h0000_0004);
    lookup("R6 overwrite clears old bit", d);
    check("R6 overwritten bit rejected", {31'd0, resp_accept}, 32'd0);
    lookup("R6 new bit present", mk(12'h122, 1'b1));
  endtask

  task automatic t_promisc;
    for (int i = 0; i < 128; i++) write_word(i, 32'h0);
    mc_promisc = 1'b1;
    lookup("R8 mc promisc empty table", mk(12'h777, 1'b1));
    check("R8 accepted", {31'd0, resp_accept}, 32'd1);
    mc_promisc = 1'b0;
    for (int i = 0; i < 128; i++) write_word(i, 32'hffff_ffff);
    uc_promisc = 1'b0;
    lookup("R9 unicast full table rejected", mk(12'h777, 1'b0));
    check("R9 unicast off", {31'd0, resp_accept}, 32'd0);
    uc_promisc = 1'b1;
    lookup("R9 unicast promisc accepted", 48'h0000_0000_0002);
    mc_promisc = 1'b1;
    uc_promisc = 1'b0;
    lookup("R9 mc promisc no effect on unicast", 48'hffff_ffff_fffe);
    mc_promisc = 1'b0;
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 128; i++) write_word(i, (i * 32'h9e37_79b9) ^ (32'h0f0f_3355 << (i % 7)));
    for (int n = 0; n < 600; n++) begin
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      cfg_short_hash = seed[60];
      cfg_offset = seed[62:61];
      mc_promisc = (seed[59:57] == 3'd0);
      uc_promisc = seed[56];
      lookup("R5 sweep", {seed[47:1], seed[55] | seed[54]});
    end
    mc_promisc = 1'b0; uc_promisc = 1'b0;
  endtask

  initial begin
    t_reset;
    t_timing;
    t_index;
    t_offsets;
    t_short;
    t_same_cycle;
    t_promisc;
    t_sweep;
    t_timing;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule